// File: doc/BRIEF.md
# Dual-Policy Operand Cache Write Controller

This block handles CPU store requests for a four-way set-associative data cache with 16-byte lines. A mode input selects the write policy for each request. In write-back mode a store that hits changes only the cached line and marks it dirty. A store that misses allocates a line: the controller picks a victim way, parks a dirty victim in a single-line eviction buffer, requests a line fill from external memory, and merges the store word into the returned line. In write-through mode every store goes out as one external word write. A hit also updates the cached copy. A miss leaves the cache untouched.

Each request is taken in one cycle, then looked up in the next. The CPU holds the request until the controller gives a one-cycle ready pulse. The external memory port carries two kinds of transfer: a 16-byte line fill and a single-word write. It holds a request stable until the memory acknowledges it. A dirty victim is pushed into the eviction buffer only when that buffer reports it is free. While the buffer is busy, the controller waits.

Top module: `opcache_wr_ctrl`

## Requirements
- R1: With `wb_mode`=1, a store that hits changes only the cached line and sets its dirty flag. No external write, no fill and no eviction push is issued. `cpu_ready` rises in the second cycle after the request is accepted.
- R2: With `wb_mode`=0, a store that hits issues exactly one external write (`mem_we`=1) carrying the CPU address, data and byte enables. It also merges the data into the cached line and leaves the dirty flag as it was.
- R3: With `wb_mode`=0, a store that misses issues exactly one external write and does not allocate. A later write-back store to the same line still misses.
- R4: With `wb_mode`=1, a store that misses issues exactly one line fill (`mem_we`=0) at the store address with its low four bits cleared. It issues no external write.
- R5: On a write-back miss whose victim is valid and dirty, exactly one push is made on `evb_push`. The push carries the victim's address ({victim tag, set index, 4'b0000}) and its line. The push comes before the fill request. A clean or invalid victim causes no push.
- R6: While `evb_busy` is high, no push, no fill request and no ready are given for a pending dirty victim. The controller waits for the buffer to free.
- R7: After a fill, the line holds the fill data merged with the store. Word i of `mem_rdata` is bits 32i+31:32i. The line becomes valid and dirty, so a later eviction of it returns this merged content.
- R8: The victim is the lowest-numbered invalid way. If all ways are valid, the victim comes from a 3-bit tree state per set. Bit 0 = 0 selects ways 0/1, with bit 1 picking way 1 when set. Bit 0 = 1 selects ways 2/3, with bit 2 picking way 3 when set. A hit or fill of way w sets bit 0 to the opposite pair and the pair bit to the other way of the pair.
- R9: `cpu_ready` stays low until the store has completed and is then high for exactly one cycle. A memory request holds its address and type until `mem_ack`.
- R10: Byte enable bit b covers bits 8b+7:8b of the addressed word, and address bits [3:2] select the word. Bytes whose enable is 0 keep their previous value, both on a hit merge and on a post-fill merge.
- R11: After reset, `cpu_ready`, `mem_req` and `evb_push` are low, every line is invalid and every tree state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back policy, 0 = write-through policy, sampled with the request |
| cpu_req | input | 1 | Store request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Byte address of the store |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Byte enables of the store |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | 1 = word write, 0 = line fill |
| mem_addr | output | ADDR_W | Word address for writes, line address for fills |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables (all ones on a fill) |
| mem_ack | input | 1 | Memory accepts the request; fill data valid |
| mem_rdata | input | 128 | Fill line, word i in bits 32i+31:32i |
| evb_push | output | 1 | Hand a dirty victim line to the eviction buffer |
| evb_addr | output | ADDR_W | Line address of the pushed victim |
| evb_line | output | 128 | Contents of the pushed victim |
| evb_busy | input | 1 | Eviction buffer still holds an earlier line |

## Verification
The bench keeps its own model of tags, valid and dirty flags, line data and tree state. It compares every external transfer and every eviction against that model over a long run that crowds six tags into each set. The run aims at dirty evictions that fall while the buffer is busy: a controller that ignores `evb_busy` pushes early or starts the fill first, which shows up as a wrong ordering. Partial byte enables on hits and on post-fill merges are checked through the contents of later evictions. A controller that writes whole words corrupts the evicted line. A directed sequence fills one set and then forces a replacement, so a wrong tree update evicts the wrong tag. A write-through miss followed by a write-back store to the same line catches a controller that allocates when it should not.

// File: rtl/opcw_pkg.sv
package opcw_pkg;
  localparam int WAYS       = 4;
  localparam int WAY_W      = 2;
  localparam int WORD_BITS  = 32;
  localparam int LINE_WORDS = 4;
  localparam int LINE_BITS  = WORD_BITS * LINE_WORDS;

  typedef logic [2:0]           plru_t;
  typedef logic [LINE_BITS-1:0] line_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_EVICT, S_FILL, S_WTWR, S_RESP
  } state_t;

  // Tree state: bit0 picks the pair, bit1/bit2 pick inside the pair.
  function automatic logic [WAY_W-1:0] plru_pick(plru_t t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    return t[2] ? 2'd3 : 2'd2;
  endfunction

  // Point the tree away from the way just used.
  function automatic plru_t plru_touch(plru_t t, logic [WAY_W-1:0] w);
    plru_t n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  // Byte-enabled merge of one word into a line.
  function automatic line_t line_merge(line_t l, logic [1:0] wsel,
                                       logic [WORD_BITS-1:0] d, logic [3:0] be);
    line_t r;
    int    base;
    r    = l;
    base = int'(wsel) * WORD_BITS;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[base + b*8 +: 8] = d[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/opcw_store.sv
module opcw_store import opcw_pkg::*; #(
  parameter  int SETS  = 4,
  parameter  int TAG_W = 10,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           rd_set,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0]            rd_dirty,
  output line_t [WAYS-1:0]           rd_line,
  output plru_t                      rd_plru,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  line_t                      wr_line,
  input  logic                       wr_dirty,
  input  plru_t                      wr_plru
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  line_t            line_q  [SETS][WAYS];
  logic [WAYS-1:0]  val_q   [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  plru_t            plru_q  [SETS];

  for (genvar g = 0; g < WAYS; g++) begin : g_rd
    assign rd_tag[g]   = tag_q[rd_set][g];
    assign rd_line[g]  = line_q[rd_set][g];
    assign rd_valid[g] = val_q[rd_set][g];
    assign rd_dirty[g] = dirty_q[rd_set][g];
  end
  assign rd_plru = plru_q[rd_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s]   <= '0;
        dirty_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else if (wr_en) begin
      val_q[wr_set][wr_way]   <= 1'b1;
      dirty_q[wr_set][wr_way] <= wr_dirty;
      plru_q[wr_set]          <= wr_plru;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      line_q[wr_set][wr_way] <= wr_line;
    end
  end
endmodule

// File: rtl/opcw_lookup.sv
module opcw_lookup import opcw_pkg::*; #(
  parameter int TAG_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       check_en,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [TAG_W-1:0]           req_tag,
  input  plru_t                      plru,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = way_valid[g] && (way_tag[g] == req_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  // Lowest invalid way wins; with a full set the tree decides.
  always_comb begin
    victim_way = plru_pick(plru);
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!way_valid[w]) victim_way = WAY_W'(w);
    end
  end

  assert_single_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    check_en |-> $onehot0(match));
endmodule

// File: rtl/opcache_wr_ctrl.sv
module opcache_wr_ctrl import opcw_pkg::*; #(
  parameter  int ADDR_W = 16,
  parameter  int SETS   = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - 4 - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wb_mode,
  input  logic                 cpu_req,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [31:0]          cpu_wdata,
  input  logic [3:0]           cpu_be,
  output logic                 cpu_ready,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [31:0]          mem_wdata,
  output logic [3:0]           mem_be,
  input  logic                 mem_ack,
  input  logic [127:0]         mem_rdata,
  output logic                 evb_push,
  output logic [ADDR_W-1:0]    evb_addr,
  output logic [127:0]         evb_line,
  input  logic                 evb_busy
);
  state_t              state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, evb_addr_q;
  logic [31:0]         data_q;
  logic [3:0]          be_q;
  logic                mode_q;
  logic [WAY_W-1:0]    way_q;
  line_t               evb_line_q;

  logic [IDX_W-1:0]    req_set;
  logic [TAG_W-1:0]    req_tag;
  logic [1:0]          req_word;

  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]     rd_valid, rd_dirty;
  line_t [WAYS-1:0]    rd_line;
  plru_t               rd_plru;
  logic                hit;
  logic [WAY_W-1:0]    hit_way, victim_way;

  logic                wr_en, wr_dirty;
  logic [WAY_W-1:0]    wr_way;
  line_t               wr_line;
  plru_t               wr_plru;

  // Named internal events.
  logic ev_accept, ev_decide, ev_wb_hit, ev_wt_hit, ev_wb_miss;
  logic ev_dirty_victim, ev_fill_done;

  assign req_set  = addr_q[4 +: IDX_W];
  assign req_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign req_word = addr_q[3:2];

  assign ev_accept       = (state_q == S_IDLE) && cpu_req;
  assign ev_decide       = (state_q == S_LOOKUP);
  assign ev_wb_hit       = ev_decide && mode_q && hit;
  assign ev_wt_hit       = ev_decide && !mode_q && hit;
  assign ev_wb_miss      = ev_decide && mode_q && !hit;
  assign ev_dirty_victim = ev_wb_miss && rd_valid[victim_way] && rd_dirty[victim_way];
  assign ev_fill_done    = (state_q == S_FILL) && mem_ack;

  opcw_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(req_set),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .rd_line(rd_line), .rd_plru(rd_plru),
    .wr_en(wr_en), .wr_set(req_set), .wr_way(wr_way), .wr_tag(req_tag),
    .wr_line(wr_line), .wr_dirty(wr_dirty), .wr_plru(wr_plru)
  );

  opcw_lookup #(.TAG_W(TAG_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .check_en(ev_decide),
    .way_tag(rd_tag), .way_valid(rd_valid), .req_tag(req_tag), .plru(rd_plru),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
  );

  always_comb begin
    wr_en    = 1'b0;
    wr_way   = hit_way;
    wr_line  = rd_line[hit_way];
    wr_dirty = rd_dirty[hit_way];
    wr_plru  = rd_plru;
    if (ev_wb_hit || ev_wt_hit) begin
      wr_en    = 1'b1;
      wr_line  = line_merge(rd_line[hit_way], req_word, data_q, be_q);
      wr_dirty = mode_q ? 1'b1 : rd_dirty[hit_way];
      wr_plru  = plru_touch(rd_plru, hit_way);
    end else if (ev_fill_done) begin
      wr_en    = 1'b1;
      wr_way   = way_q;
      wr_line  = line_merge(mem_rdata, req_word, data_q, be_q);
      wr_dirty = 1'b1;
      wr_plru  = plru_touch(rd_plru, way_q);
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (cpu_req) state_d = S_LOOKUP;
      S_LOOKUP: begin
        if (ev_wb_hit)            state_d = S_RESP;
        else if (!mode_q)         state_d = S_WTWR;
        else if (ev_dirty_victim) state_d = S_EVICT;
        else                      state_d = S_FILL;
      end
      S_EVICT:  if (!evb_busy) state_d = S_FILL;
      S_FILL:   if (mem_ack)   state_d = S_RESP;
      S_WTWR:   if (mem_ack)   state_d = S_RESP;
      S_RESP:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (ev_accept) begin
      addr_q <= cpu_addr;
      data_q <= cpu_wdata;
      be_q   <= cpu_be;
      mode_q <= wb_mode;
    end
    if (ev_wb_miss) begin
      way_q      <= victim_way;
      evb_addr_q <= {rd_tag[victim_way], req_set, 4'b0000};
      evb_line_q <= rd_line[victim_way];
    end
  end

  assign cpu_ready = (state_q == S_RESP);
  assign mem_req   = (state_q == S_FILL) || (state_q == S_WTWR);
  assign mem_we    = (state_q == S_WTWR);
  assign mem_addr  = mem_we ? addr_q : {addr_q[ADDR_W-1:4], 4'b0000};
  assign mem_wdata = data_q;
  assign mem_be    = mem_we ? be_q : 4'hF;
  assign evb_push  = (state_q == S_EVICT) && !evb_busy;
  assign evb_addr  = evb_addr_q;
  assign evb_line  = evb_line_q;

  assert_wb_no_ext_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mode_q);
  assert_wt_no_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> mode_q);
  assert_victim_before_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dirty_victim |=> !mem_req);
  assert_fill_after_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evb_push |=> (mem_req && !mem_we));
  assert_stall_on_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_EVICT) && evb_busy) |=> (!mem_req && !cpu_ready));
  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/opcache_wr_ctrl_bench.sv
module opcache_wr_ctrl_bench;
  localparam int CLK_HALF = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wb_mode = 1'b0, cpu_req = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic         cpu_ready;
  logic         mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic [3:0]   mem_be;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;
  logic         evb_push;
  logic [15:0]  evb_addr;
  logic [127:0] evb_line;
  logic         evb_busy = 1'b0;

  int tests = 0, fails = 0;
  logic [31:0] rng = 32'h1234_5677;

  // Reference model
  logic [9:0]   m_tag  [4][4];
  bit           m_v    [4][4];
  bit           m_d    [4][4];
  logic [127:0] m_line [4][4];
  logic [2:0]   m_plru [4];

  logic [15:0]  lp_addr;
  logic [127:0] lp_line;
  int           l_nfill, l_npush;

  always #CLK_HALF clk = ~clk;

  opcache_wr_ctrl #(.ADDR_W(16), .SETS(4)) u_opcache_wr_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .evb_push(evb_push), .evb_addr(evb_addr), .evb_line(evb_line), .evb_busy(evb_busy)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] fill_line(logic [15:0] la);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = {la ^ 16'hBEEF, 8'(i*37), 8'h5A};
    return r;
  endfunction

  function automatic logic [127:0] b_merge(logic [127:0] l, int w, logic [31:0] d,
                                           logic [3:0] be);
    logic [127:0] mm;
    mm = {96'b0, {8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} << (w*32);
    return (l & ~mm) | (({96'b0, d} << (w*32)) & mm);
  endfunction

  function automatic int b_pick(int s);
    for (int k = 0; k < 4; k++) if (!m_v[s][k]) return k;
    return m_plru[s][0] ? 2 + int'(m_plru[s][2]) : int'(m_plru[s][1]);
  endfunction

  function automatic logic [2:0] b_touch(logic [2:0] p, int w);
    logic [2:0] n;
    n = p;
    case (w)
      0: begin n[0] = 1'b1; n[1] = 1'b1; end
      1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction

  task automatic run_op(input bit mode, input logic [15:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int busy_n, input int dly);
    int s, w, hw, vw, cyc, n_wr, n_fill, n_push, push_cyc, fill_cyc, viol, left;
    bit hit, e_push, seen, done;
    logic [9:0] t;
    logic [15:0] e_paddr, wr_addr, fill_addr, push_addr;
    logic [127:0] e_pline, push_line;
    logic [31:0] wr_data;
    logic [3:0] wr_be;
    string rq;
    s = int'(a[5:4]); w = int'(a[3:2]); t = a[15:6];
    hit = 0; hw = 0; cyc = 0; n_wr = 0; n_fill = 0; n_push = 0;
    push_cyc = 0; fill_cyc = 0; viol = 0; left = 0; seen = 0; done = 0;
    wr_addr = '0; fill_addr = '0; push_addr = '0; push_line = '0; wr_data = '0; wr_be = '0;
    for (int k = 0; k < 4; k++) if (m_v[s][k] && m_tag[s][k] == t) begin hit = 1; hw = k; end
    vw = b_pick(s);
    e_push  = mode && !hit && m_v[s][vw] && m_d[s][vw];
    e_paddr = {m_tag[s][vw], 2'(s), 4'b0000};
    e_pline = m_line[s][vw];

    wb_mode = mode; cpu_addr = a; cpu_wdata = d; cpu_be = be; cpu_req = 1'b1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      mem_ack  = 1'b0;
      evb_busy = (cyc <= busy_n);
      #1;
      if (cpu_ready) done = 1;
      else begin
        if (evb_push) begin
          n_push++; push_cyc = cyc; push_addr = evb_addr; push_line = evb_line;
          if (evb_busy) viol++;
        end
        if (mem_req) begin
          if (e_push && n_push == 0) viol++;
          if (!seen) begin
            seen = 1; left = dly;
            if (mem_we) begin
              n_wr++; wr_addr = mem_addr; wr_data = mem_wdata; wr_be = mem_be;
            end else begin
              n_fill++; fill_cyc = cyc; fill_addr = mem_addr;
            end
          end
          if (left == 0) begin
            mem_ack = 1'b1; mem_rdata = fill_line(mem_addr); seen = 0;
          end else left--;
        end
      end
    end
    cpu_req = 1'b0; evb_busy = 1'b0;
    if (!done) begin
      fails++; tests++;
      $display("FAIL R9 watchdog: ready never came actual=%0d expected=<60", cyc);
    end
    lp_addr = push_addr; lp_line = push_line; l_nfill = n_fill; l_npush = n_push;

    if (mode && hit) begin
      chk(cyc == 2, "R1", "write-back hit latency", 128'(cyc), 128'd2);
      chk(n_wr + n_fill + n_push == 0, "R1", "no traffic on write-back hit",
          128'(n_wr + n_fill + n_push), 128'd0);
    end
    if (!mode) begin
      rq = hit ? "R2" : "R3";
      chk(n_wr == 1 && n_fill == 0 && n_push == 0, rq, "single external write",
          128'(n_wr*100 + n_fill*10 + n_push), 128'd100);
      chk(wr_addr == a && wr_data == d && wr_be == be, rq, "external write fields",
          {76'b0, wr_addr, wr_data, wr_be}, {76'b0, a, d, be});
    end
    if (mode && !hit) begin
      chk(n_fill == 1 && n_wr == 0, "R4", "single line fill",
          128'(n_fill*10 + n_wr), 128'd10);
      chk(fill_addr == {a[15:4], 4'b0000}, "R4", "fill address",
          128'(fill_addr), 128'({a[15:4], 4'b0000}));
      chk(n_push == (e_push ? 1 : 0), "R5", "eviction push count",
          128'(n_push), 128'(e_push ? 1 : 0));
      if (e_push) begin
        chk(push_addr == e_paddr, "R5", "victim address", 128'(push_addr), 128'(e_paddr));
        chk(push_line == e_pline, "R7", "victim line content", push_line, e_pline);
        chk(push_cyc < fill_cyc, "R5", "push before fill", 128'(push_cyc), 128'(fill_cyc));
        chk(push_cyc > busy_n, "R6", "push waits for buffer", 128'(push_cyc), 128'(busy_n + 1));
      end
      chk(viol == 0, "R6", "no push or fill while buffer busy", 128'(viol), 128'd0);
    end

    @(negedge clk);
    #1;
    chk(!cpu_ready, "R9", "ready lasts one cycle", 128'(cpu_ready), 128'd0);

    if (hit) begin
      m_line[s][hw] = b_merge(m_line[s][hw], w, d, be);
      if (mode) m_d[s][hw] = 1;
      m_plru[s] = b_touch(m_plru[s], hw);
    end else if (mode) begin
      m_line[s][vw] = b_merge(fill_line({a[15:4], 4'b0000}), w, d, be);
      m_tag[s][vw] = t; m_v[s][vw] = 1; m_d[s][vw] = 1;
      m_plru[s] = b_touch(m_plru[s], vw);
    end
  endtask

  function automatic logic [31:0] next_rng(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    #(2*CLK_HALF*190000);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [127:0] exp_line;
    for (int s = 0; s < 4; s++) begin
      m_plru[s] = '0;
      for (int k = 0; k < 4; k++) begin
        m_v[s][k] = 0; m_d[s][k] = 0; m_tag[s][k] = '0; m_line[s][k] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!cpu_ready && !mem_req && !evb_push, "R11", "idle outputs after reset",
        {125'b0, cpu_ready, mem_req, evb_push}, 128'd0);

    // First access into an empty set: miss, nothing to evict.
    run_op(1'b1, 16'h0044, 32'h1122_3344, 4'b0101, 0, 1);
    chk(l_nfill == 1 && l_npush == 0, "R11", "empty set after reset",
        128'(l_nfill*10 + l_npush), 128'd10);
    run_op(1'b1, 16'h0048, 32'hA5A5_A5A5, 4'hF, 0, 0);
    run_op(1'b0, 16'h004C, 32'hCAFE_BABE, 4'b0011, 0, 2);
    run_op(1'b1, 16'h0080, 32'h0000_0001, 4'hF, 0, 0);
    run_op(1'b1, 16'h00C0, 32'h0000_0002, 4'hF, 0, 1);
    run_op(1'b1, 16'h0100, 32'h0000_0003, 4'hF, 0, 0);
    // Set 0 full; tree now points at way 0 (tag 1, line 0x0040).
    run_op(1'b1, 16'h0140, 32'h0000_0004, 4'hF, 5, 1);
    chk(lp_addr == 16'h0040, "R8", "tree victim after filling ways 0..3",
        128'(lp_addr), 128'h0040);
    exp_line = fill_line(16'h0040);
    exp_line[39:32]  = 8'h44;
    exp_line[55:48]  = 8'h22;
    exp_line[95:64]  = 32'hA5A5_A5A5;
    exp_line[111:96] = 16'hBABE;
    chk(lp_line == exp_line, "R10", "partial byte merges in evicted line", lp_line, exp_line);

    // Write-through miss must not allocate.
    run_op(1'b0, 16'h01D0, 32'h5555_AAAA, 4'hF, 0, 0);
    run_op(1'b1, 16'h01D0, 32'h7777_8888, 4'hF, 0, 0);
    chk(l_nfill == 1, "R3", "line still absent after write-through miss",
        128'(l_nfill), 128'd1);

    for (int n = 0; n < 900; n++) begin
      logic [15:0] a;
      bit md;
      rng = next_rng(rng);
      a  = {4'b0, 6'(rng[7:0] % 6), rng[9:8], rng[11:10], rng[13:12]};
      md = (rng[15:14] != 2'b00);
      run_op(md, a, rng ^ 32'h3C3C_0F0F, rng[19:16], int'(rng[21:20]), int'(rng[23:22]) % 3);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule